// File: doc/BRIEF.md
# Time-Multiplexed Adaptive FIR Engine

This block is a ten-tap adaptive FIR filter built around a single shared multiplier. A small sequencer walks one pipelined multiply-accumulate unit over the taps, one tap per clock, instead of giving each tap its own multiplier. Every accepted input sample costs two passes of equal length. The first pass forms the filter output. The second pass adapts every coefficient by a least-mean-squares step, where the error is the desired response minus the output.

Each pass lasts 17 clocks: one setup cycle, ten issue cycles, four cycles for the MAC pipeline to drain, and two cycles to wrap up. While the two passes run, the engine reports busy and refuses new samples and coefficient writes. The step size is a power of two, given as a right-shift count that is sampled together with each input sample. Before adaptation starts, a simple write port loads the coefficients.

Top module: `lms_fir_engine`

## Requirements
- R1: A synchronous active-low reset clears the sample history, the coefficients and the accumulator, and returns the engine to idle. After reset `busy`, `y_valid` and `y_data` are all 0.
- R2: A sample is accepted at a rising edge where `smp_valid` is 1 and `busy` is 0. At that edge `desired` and `mu_shift` are captured with it, and the history shifts so that the new sample becomes tap 0 and tap k takes the old tap k-1.
- R3: The output is y = sat16((sum over k of c[k]*x[k] + 2^14) >>> 15), computed with a 40-bit accumulator and an arithmetic shift. sat16 clamps to the range -32768..32767.
- R4: `y_valid` is 1 for exactly one cycle. That cycle is the 16th cycle after the acceptance edge. `y_data` holds the new output in that cycle.
- R5: `busy` is 1 for 34 cycles after the acceptance edge, which is two passes of 17 clocks each, and returns to 0 in the next cycle.
- R6: After the output is formed, e = sat16(desired - y). Each coefficient then becomes c[k] + ((e*x[k]) >>> mu_shift), where x[k] is the same history used for the output and the shift is arithmetic on the 32-bit product. The effect shows in the next sample's output.
- R7: A coefficient write with `coef_wr_en` = 1 while idle stores `coef_wr_data` into tap `coef_wr_addr` (tap 0 pairs with the newest sample). Writes to addresses 10 to 15 are ignored, and so are writes made while `busy` is 1.
- R8: `smp_valid` asserted while `busy` is 1 is ignored. It changes neither the history nor the timing.
- R9: A coefficient update that leaves the 16-bit range saturates to -32768 or 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | New input sample offered |
| smp_data | input | 16 | Signed input sample |
| desired | input | 16 | Signed desired response for this sample |
| mu_shift | input | 5 | Step size as a right-shift count |
| coef_wr_en | input | 1 | Coefficient write strobe |
| coef_wr_addr | input | 4 | Tap index of the write |
| coef_wr_data | input | 16 | Signed coefficient value |
| busy | output | 1 | Engine is running its two passes |
| y_valid | output | 1 | One-cycle output strobe |
| y_data | output | 16 | Signed filter output |

## Verification
Impulse samples read the loaded coefficients back tap by tap through the output, which separates tap ordering from history shifting. Inputs near ±2^14 on a unit coefficient check the rounding rule at its ties, and full-scale inputs on full-scale coefficients drive the output into both saturation limits. Pseudo-random input streams with offset desired responses are run over a sweep of shift counts. In these runs every output depends on all earlier updates, so an error in the update rule, the shift or coefficient saturation (small shifts with large errors) carries into later outputs. Samples, writes to unused addresses and writes made while busy are then followed by outputs that show whether they changed any state.

// File: rtl/lms_fir_pkg.sv
// Shared types for the adaptive FIR engine.
// Assumes: nothing beyond IEEE 1800-2017.
package lms_fir_pkg;

    // Engine phase: waiting, forming the output, adapting coefficients.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FILTER = 2'd1,
        PH_ADAPT  = 2'd2
    } eng_phase_t;

endpackage

// File: rtl/lms_fir_sat.sv
// Signed saturating narrower: clamps a wide two's-complement value to OW bits.
// Assumes: IW > OW.
module lms_fir_sat #(
    parameter int IW = 40,
    parameter int OW = 16
) (
    input  logic [IW-1:0] din,
    output logic [OW-1:0] dout
);
    localparam int HW = IW - OW + 1;

    logic [HW-1:0] head;
    logic          fits;

    // Value fits when every bit above the output sign matches it.
    always_comb begin
        head = din[IW-1:OW-1];
        fits = (&head) || !(|head);
        if (fits)
            dout = din[OW-1:0];
        else if (din[IW-1])
            dout = {1'b1, {(OW-1){1'b0}}};
        else
            dout = {1'b0, {(OW-1){1'b1}}};
    end
endmodule

// File: rtl/lms_fir_seq.sv
// Pass sequencer: after a start it runs a filter pass then an adapt pass,
// each PASS_LEN cycles: setup, TAPS issue cycles, MAC_LAT drain cycles,
// then two wrap-up cycles (output capture, pass end).
// Assumes: start is only honoured while idle.
module lms_fir_seq
    import lms_fir_pkg::*;
#(
    parameter int TAPS    = 10,
    parameter int MAC_LAT = 4,
    parameter int IW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          acc_clr,
    output logic          issue,
    output logic          adapt_mode,
    output logic          cap_out,
    output logic [IW-1:0] tap_idx
);
    localparam int PASS_LEN = TAPS + MAC_LAT + 3;
    localparam int CW       = $clog2(PASS_LEN);
    localparam logic [CW-1:0] LAST_C = CW'(PASS_LEN - 1);
    localparam logic [CW-1:0] CAP_C  = CW'(PASS_LEN - 2);
    localparam logic [CW-1:0] TAPS_C = CW'(TAPS);

    eng_phase_t    phase_q;
    logic [CW-1:0] cnt_q;

    // Phase and in-pass cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start) phase_q <= PH_FILTER;
                end
                PH_FILTER: begin
                    if (cnt_q == LAST_C) begin
                        cnt_q   <= '0;
                        phase_q <= PH_ADAPT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == LAST_C) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Decode of the current cycle into MAC controls.
    always_comb begin
        busy       = (phase_q != PH_IDLE);
        adapt_mode = (phase_q == PH_ADAPT);
        acc_clr    = (phase_q == PH_FILTER) && (cnt_q == '0);
        issue      = busy && (cnt_q != '0) && (cnt_q <= TAPS_C);
        cap_out    = (phase_q == PH_FILTER) && (cnt_q == CAP_C);
        tap_idx    = IW'(cnt_q - 1'b1);
    end

    // The counter never leaves its pass range (R5 timing depends on it).
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST_C));

    // An idle engine with no start stays idle.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/lms_fir_mac.sv
// Shared pipelined multiplier: product registered, then MAC_LAT-2 delay stages,
// and at the final stage the product either adds into the accumulator
// (filter mode) or is presented for coefficient write-back (adapt mode).
// Assumes: MAC_LAT >= 2; clr never coincides with a product in flight.
module lms_fir_mac #(
    parameter int DW      = 16,
    parameter int ACC_W   = 40,
    parameter int MAC_LAT = 4,
    parameter int IW      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic                    in_adapt,
    input  logic [IW-1:0]           in_idx,
    input  logic signed [DW-1:0]    op_a,
    input  logic signed [DW-1:0]    op_b,
    output logic signed [ACC_W-1:0] acc,
    output logic                    wb_valid,
    output logic [IW-1:0]           wb_idx,
    output logic signed [2*DW-1:0]  wb_prod
);
    localparam int PW  = 2 * DW;
    localparam int NST = MAC_LAT - 1;

    logic signed [PW-1:0] prod_q [NST];
    logic                 vld_q  [NST];
    logic                 adp_q  [NST];
    logic [IW-1:0]        idx_q  [NST];

    // Product pipeline with its tag bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NST; s++) begin
                prod_q[s] <= '0;
                vld_q[s]  <= 1'b0;
                adp_q[s]  <= 1'b0;
                idx_q[s]  <= '0;
            end
        end else begin
            prod_q[0] <= op_a * op_b;
            vld_q[0]  <= in_valid;
            adp_q[0]  <= in_adapt;
            idx_q[0]  <= in_idx;
            for (int s = 1; s < NST; s++) begin
                prod_q[s] <= prod_q[s-1];
                vld_q[s]  <= vld_q[s-1];
                adp_q[s]  <= adp_q[s-1];
                idx_q[s]  <= idx_q[s-1];
            end
        end
    end

    // Accumulator: cleared at pass setup, adds filter-mode products.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (vld_q[NST-1] && !adp_q[NST-1])
            acc <= acc + {{(ACC_W-PW){prod_q[NST-1][PW-1]}}, prod_q[NST-1]};
    end

    assign wb_valid = vld_q[NST-1] && adp_q[NST-1];
    assign wb_idx   = idx_q[NST-1];
    assign wb_prod  = prod_q[NST-1];

    // A clear always leaves the accumulator at zero on the next cycle (R3).
    assert_acc_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/lms_fir_regs.sv
// Sample history shift register and coefficient file.
// Host writes land only when the engine is idle; adapt write-back only when busy.
// Assumes: the two write sources are never active together.
module lms_fir_regs #(
    parameter int DW   = 16,
    parameter int TAPS = 10,
    parameter int IW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy_i,
    input  logic                 push,
    input  logic signed [DW-1:0] push_data,
    input  logic                 host_we,
    input  logic [IW-1:0]        host_addr,
    input  logic signed [DW-1:0] host_data,
    input  logic                 upd_we,
    input  logic [IW-1:0]        upd_idx,
    input  logic signed [DW-1:0] upd_data,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] hist_rd,
    output logic signed [DW-1:0] coef_rd,
    output logic signed [DW-1:0] coef_at_upd
);
    localparam logic [IW-1:0] TAPS_I = IW'(TAPS);

    logic signed [DW-1:0] hist_q [TAPS];
    logic signed [DW-1:0] coef_q [TAPS];

    // History: newest sample enters tap 0 on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) hist_q[k] <= '0;
        end else if (push) begin
            hist_q[0] <= push_data;
            for (int k = 1; k < TAPS; k++) hist_q[k] <= hist_q[k-1];
        end
    end

    // Coefficients: host preload or adapt write-back, in-range addresses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) coef_q[k] <= '0;
        end else if (host_we && (host_addr < TAPS_I)) begin
            coef_q[host_addr] <= host_data;
        end else if (upd_we && (upd_idx < TAPS_I)) begin
            coef_q[upd_idx] <= upd_data;
        end
    end

    // Read ports, zero for out-of-range indices.
    always_comb begin
        hist_rd     = (rd_idx  < TAPS_I) ? hist_q[rd_idx]  : '0;
        coef_rd     = (rd_idx  < TAPS_I) ? coef_q[rd_idx]  : '0;
        coef_at_upd = (upd_idx < TAPS_I) ? coef_q[upd_idx] : '0;
    end

    // History never moves while the engine is busy.
    assert_hist_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (hist_q[0] == $past(hist_q[0]) && hist_q[TAPS-1] == $past(hist_q[TAPS-1])));
endmodule

// File: rtl/lms_fir_engine.sv
// Top: ten-tap adaptive FIR with one shared pipelined MAC.
// Each accepted sample runs a filter pass (output + error) and an adapt pass
// (coefficient update, step = product >>> mu_shift), both with saturation.
// Assumes: coefficients in Q1.15, samples signed; inputs synchronous to clk.
module lms_fir_engine
    import lms_fir_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TAPS    = 10,
    parameter int ACC_W   = 40,
    parameter int FRAC    = 15,
    parameter int MAC_LAT = 4,
    parameter int SHW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic [DW-1:0] desired,
    input  logic [SHW-1:0] mu_shift,
    input  logic          coef_wr_en,
    input  logic [$clog2(TAPS)-1:0] coef_wr_addr,
    input  logic [DW-1:0] coef_wr_data,
    output logic          busy,
    output logic          y_valid,
    output logic [DW-1:0] y_data
);
    localparam int IW = $clog2(TAPS);
    localparam int PW = 2 * DW;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (FRAC - 1);

    logic                    accept, acc_clr, issue, adapt_mode, cap_out;
    logic [IW-1:0]           tap_idx;
    logic signed [DW-1:0]    hist_rd, coef_rd, coef_at_upd, op_a;
    logic signed [ACC_W-1:0] acc, acc_sh;
    logic                    wb_valid;
    logic [IW-1:0]           wb_idx;
    logic signed [PW-1:0]    wb_prod, step;
    logic [DW-1:0]           y_next, err_next, coef_next;
    logic [DW:0]             diff;
    logic [PW:0]             upd_sum;
    logic [DW-1:0]           desired_q, err_q, y_q;
    logic [SHW-1:0]          mu_q;
    logic                    y_valid_q;

    assign accept = smp_valid && !busy;

    lms_fir_seq #(.TAPS(TAPS), .MAC_LAT(MAC_LAT), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy),
        .acc_clr(acc_clr), .issue(issue), .adapt_mode(adapt_mode),
        .cap_out(cap_out), .tap_idx(tap_idx)
    );

    lms_fir_regs #(.DW(DW), .TAPS(TAPS), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .busy_i(busy),
        .push(accept), .push_data(smp_data),
        .host_we(coef_wr_en && !busy), .host_addr(coef_wr_addr), .host_data(coef_wr_data),
        .upd_we(wb_valid), .upd_idx(wb_idx), .upd_data(coef_next),
        .rd_idx(tap_idx), .hist_rd(hist_rd), .coef_rd(coef_rd), .coef_at_upd(coef_at_upd)
    );

    // Filter pass multiplies coefficient by sample; adapt pass multiplies error by sample.
    assign op_a = adapt_mode ? signed'(err_q) : coef_rd;

    lms_fir_mac #(.DW(DW), .ACC_W(ACC_W), .MAC_LAT(MAC_LAT), .IW(IW)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .in_valid(issue),
        .in_adapt(adapt_mode), .in_idx(tap_idx), .op_a(op_a), .op_b(hist_rd),
        .acc(acc), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_prod(wb_prod)
    );

    // Output: round half up, drop the fraction, saturate.
    assign acc_sh = (acc + RND) >>> FRAC;
    lms_fir_sat #(.IW(ACC_W), .OW(DW)) u_sat_y (.din(acc_sh), .dout(y_next));

    // Error against the captured desired response.
    assign diff = {desired_q[DW-1], desired_q} - {y_next[DW-1], y_next};
    lms_fir_sat #(.IW(DW+1), .OW(DW)) u_sat_e (.din(diff), .dout(err_next));

    // Coefficient update: scaled product added to the current value.
    assign step    = wb_prod >>> mu_q;
    assign upd_sum = {{(PW-DW+1){coef_at_upd[DW-1]}}, coef_at_upd} + {step[PW-1], step};
    lms_fir_sat #(.IW(PW+1), .OW(DW)) u_sat_c (.din(upd_sum), .dout(coef_next));

    // Per-sample captures: desired and step size at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desired_q <= '0;
            mu_q      <= '0;
        end else if (accept) begin
            desired_q <= desired;
            mu_q      <= mu_shift;
        end
    end

    // Output register, valid strobe and error register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q       <= '0;
            err_q     <= '0;
            y_valid_q <= 1'b0;
        end else begin
            y_valid_q <= cap_out;
            if (cap_out) begin
                y_q   <= y_next;
                err_q <= err_next;
            end
        end
    end

    assign y_valid = y_valid_q;
    assign y_data  = y_q;

    // Acceptance starts the engine.
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !busy) |=> busy);

    // Output strobe lasts one cycle.
    assert_yvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid);

    // Output strobe only inside a busy window.
    assert_yvalid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> busy);

    // Output data only changes together with a strobe.
    assert_ydata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid |=> (y_valid || $stable(y_data)));
endmodule

// File: tb/lms_fir_engine_bench.sv
// Bench for lms_fir_engine: arithmetic reference model, directed patterns and
// a sweep of step sizes over pseudo-random streams.
module lms_fir_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [15:0] desired = '0;
    logic [4:0]  mu_shift = '0;
    logic        coef_wr_en = 1'b0;
    logic [3:0]  coef_wr_addr = '0;
    logic [15:0] coef_wr_data = '0;
    logic        busy, y_valid;
    logic [15:0] y_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mh [10];
    int mc [10];
    int lf = 16'hACE1;

    always #2 clk = ~clk;

    lms_fir_engine u_lms_fir_engine (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .desired(desired), .mu_shift(mu_shift), .coef_wr_en(coef_wr_en),
        .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
        .busy(busy), .y_valid(y_valid), .y_data(y_data)
    );

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int next_rand();
        lf = (lf & 1) ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
        return lf - 32768;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Host coefficient write while idle; model follows R7.
    task automatic wr_coef(int addr, int val);
        @(negedge clk);
        coef_wr_en = 1'b1; coef_wr_addr = 4'(addr); coef_wr_data = 16'(val);
        @(posedge clk);
        @(negedge clk);
        coef_wr_en = 1'b0;
        if (addr < 10) mc[addr] = val;
    endtask

    // One sample through both passes; poke injects ignored stimulus while busy.
    task automatic run_sample(int xs, int delta, int mu, string req, bit poke);
        longint acc = 0;
        int y_exp, d, e, yv_bad, busy_bad, got_y;
        for (int k = 9; k > 0; k--) mh[k] = mh[k-1];
        mh[0] = xs;
        for (int k = 0; k < 10; k++) acc += longint'(mc[k]) * longint'(mh[k]);
        y_exp = sat16((acc + 16384) >>> 15);
        d = sat16(longint'(y_exp) + delta);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 16'(xs); desired = 16'(d); mu_shift = 5'(mu);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        yv_bad = 0; busy_bad = 0; got_y = 0;
        for (int n = 0; n <= 36; n++) begin
            if (y_valid !== (n == 16)) yv_bad++;
            if (busy !== (n <= 33)) busy_bad++;
            if (n == 16) got_y = int'($signed(y_data));
            if (poke && n == 5) begin
                smp_valid = 1'b1; smp_data = 16'h1234; mu_shift = 5'd0;
                coef_wr_en = 1'b1; coef_wr_addr = 4'd0; coef_wr_data = 16'd5555;
            end
            if (poke && n == 6) begin
                smp_valid = 1'b0; coef_wr_en = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk(got_y == y_exp, req, "y_data", got_y, y_exp);
        chk(yv_bad == 0, "R4", "y_valid timing mismatches", yv_bad, 0);
        chk(busy_bad == 0, "R5", "busy timing mismatches", busy_bad, 0);
        // Model the adapt pass (R6, R9).
        e = sat16(longint'(d) - y_exp);
        for (int k = 0; k < 10; k++)
            mc[k] = sat16(longint'(mc[k]) + ((longint'(e) * longint'(mh[k])) >>> mu));
    endtask

    initial begin
        for (int k = 0; k < 10; k++) begin mh[k] = 0; mc[k] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(y_valid == 1'b0, "R1", "y_valid after reset", y_valid, 0);
        chk(y_data == 16'd0, "R1", "y_data after reset", y_data, 0);
        // R1: cleared coefficients give zero output
        run_sample(1000, 0, 8, "R1", 1'b0);

        // R7: preload, including an ignored out-of-range address
        for (int k = 0; k < 10; k++) wr_coef(k, (k + 1) * 1100 - 4000 * (k % 2));
        wr_coef(12, 999);
        wr_coef(15, -999);
        // R2: impulse walks each coefficient to the output in tap order
        run_sample(32767, 0, 8, "R2", 1'b0);
        for (int i = 0; i < 9; i++) run_sample(0, 0, 8, "R2", 1'b0);

        // R3: rounding ties on a unit coefficient
        for (int k = 0; k < 10; k++) wr_coef(k, (k == 0) ? 1 : 0);
        run_sample(16384, 0, 31, "R3", 1'b0);
        run_sample(16383, 0, 31, "R3", 1'b0);
        run_sample(-16384, 0, 31, "R3", 1'b0);
        run_sample(-16385, 0, 31, "R3", 1'b0);

        // R3: saturation at both limits
        for (int k = 0; k < 10; k++) wr_coef(k, 32767);
        for (int i = 0; i < 10; i++) run_sample(32767, 0, 31, "R3", 1'b0);
        for (int i = 0; i < 10; i++) run_sample(-32768, 0, 31, "R3", 1'b0);

        // R7, R8: writes and samples during busy leave state untouched
        for (int k = 0; k < 10; k++) wr_coef(k, 300 * k - 1200);
        run_sample(20000, 0, 31, "R8", 1'b1);
        run_sample(-7000, 0, 31, "R8", 1'b1);
        for (int i = 0; i < 3; i++) run_sample(0, 0, 31, "R7", 1'b0);

        // R6, R9: adaptation over a sweep of step sizes
        for (int m = 0; m <= 5; m++) begin
            int mu = (m == 0) ? 0 : 2 + 4 * m;
            for (int k = 0; k < 10; k++) wr_coef(k, 500 - 97 * k);
            for (int i = 0; i < 10; i++) begin
                int xs = next_rand();
                int dl = (next_rand() % 4001) - 2000;
                run_sample(xs, dl, mu, (mu < 8) ? "R9" : "R6", 1'b0);
            end
        end

        // R1: reset in the middle of nothing clears coefficients and history
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin mh[k] = 0; mc[k] = 0; end
        run_sample(12345, 0, 8, "R1", 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule